// File: doc/BRIEF.md
# Ethernet Transmit Control Sequencer

This block decides when a simple Ethernet MAC may put a frame on the line. It keeps a three-bit transmit control word (full duplex, heartbeat check, graceful stop), watches carrier sense and collision from the line side, and moves bytes from a frame queue onto the transmit byte stream. The queue shows whether a frame is waiting, the byte at its head and an end-of-frame marker. The sequencer tells the queue when to advance by one byte, when to rewind the current frame to its first byte, and when to throw the current frame away.

A graceful stop lets the frame on the wire finish and then raises a sticky stop-complete event. If the block is idle, the event is raised at once. A collision early in a frame while the stop is requested cuts the frame short and keeps it for a later resend. In half duplex, with the heartbeat check enabled, a window after every frame listens for the collision input and flags a sticky error if it stays quiet. Serialization, CRC, backoff and PHY signalling belong to other blocks.

Top module: `eth_tx_sequencer`

## Requirements
- R1: After reset the control word reads 0, the stop-complete and heartbeat-error flags and the interrupt are low, and no byte is sent or taken from the queue.
- R2: A control write updates bit 0 (graceful stop) at any time. Bit 2 (full duplex) and bit 1 (heartbeat check) take the written value only while `mac_en` is low; while `mac_en` is high they keep their value.
- R3: In half duplex a waiting frame starts only when `crs` is low. In full duplex `crs` has no effect on starting.
- R4: While a frame is sent, each cycle puts the head byte on `tx_data` with `tx_en` high and pulses `q_rd`. The cycle whose byte carries `q_eof` is the last byte of the frame, and `tx_data` is 0 whenever `tx_en` is low.
- R5: No frame starts, and no held frame resumes, while graceful stop is set.
- R6: When graceful stop is set during a frame, the frame completes and `stop_done` rises on the second clock edge after its last byte. When it is set while no frame is being sent, `stop_done` rises on the second edge after the write.
- R7: `stop_done` and `hb_err` stay set until cleared by a 1 on `stat_clr` bit 0 and bit 1 respectively, and a new event wins over a clear in the same cycle. `irq` equals `stop_done` while `irq_mask` is high and is low otherwise.
- R8: In half duplex, a collision while graceful stop is set and fewer than `EARLY_BYTES` bytes of the frame have been sent stops the frame: `q_rewind` pulses, no byte is taken that cycle, and the frame is held. Clearing graceful stop sends the same frame again from its first byte. A collision without graceful stop, or after the early window, has no effect.
- R9: In full duplex, collisions never stop a frame and no heartbeat check is run.
- R10: With the heartbeat check set in half duplex, the `HB_WIN` cycles after a frame's last byte form a window. A collision in the window ends it with no error. If the window ends without a collision, `hb_err` is set. No frame starts during the window, and with the check clear no window is opened.
- R11: Lowering `mac_en` while a frame is being sent or held pulses `q_drop` once, ends transmission and returns to idle. Lowering it during a heartbeat window ends the window without setting `hb_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| mac_en | input | 1 | MAC enable; low aborts and unlocks the mode bits |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 3 | Control write data: bit 2 full duplex, bit 1 heartbeat check, bit 0 graceful stop |
| ctrl_q | output | 3 | Current control word, same bit layout |
| stat_clr | input | 2 | Write-1-to-clear: bit 0 stop-complete, bit 1 heartbeat error |
| irq_mask | input | 1 | Lets stop-complete drive `irq` |
| stop_done | output | 1 | Sticky graceful-stop-complete event |
| hb_err | output | 1 | Sticky heartbeat error |
| irq | output | 1 | Interrupt request |
| q_avail | input | 1 | Queue holds at least one frame |
| q_byte | input | DATA_W | Byte at the queue head |
| q_eof | input | 1 | Head byte is the last of its frame |
| q_rd | output | 1 | Advance the queue by one byte |
| q_rewind | output | 1 | Return the queue head to the first byte of the current frame |
| q_drop | output | 1 | Discard the current frame |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| tx_en | output | 1 | Transmit byte valid |
| tx_data | output | DATA_W | Transmit byte |

## Verification
The bench builds the block with `HB_WIN` = 6 and `EARLY_BYTES` = 4, with `DATA_W` at 8. A six-cycle window lets frames with and without a collision in the window each run in a few cycles, and lets the bench load a second frame that must wait for the window to close. Four early bytes let eight-byte frames place one collision inside the early window and one after it, so both the held resend and the ignored late collision are reached.

// File: rtl/eth_txseq_pkg.sv
package eth_txseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_HELD  = 2'd2,
    ST_HBCHK = 2'd3
  } txseq_state_e;

  // control word layout
  localparam int CTL_W   = 3;
  localparam int CTL_FDX = 2;
  localparam int CTL_HBC = 1;
  localparam int CTL_GTS = 0;

  // bits that only change while the MAC is disabled
  localparam logic [CTL_W-1:0] CTL_LOCKED = 3'b110;

  // status clear positions
  localparam int CLR_W    = 2;
  localparam int CLR_STOP = 0;
  localparam int CLR_HB   = 1;

endpackage

// File: rtl/txseq_ctrl_reg.sv
module txseq_ctrl_reg
  import eth_txseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mac_en,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             arm_set
);

  logic [CTL_W-1:0] bit_en;

  genvar g;
  generate
    for (g = 0; g < CTL_W; g++) begin : g_bit
      logic bit_r;

      // mode bits are write-locked while the MAC runs
      if (CTL_LOCKED[g]) begin : g_locked
        always_comb bit_en[g] = wr_en && !mac_en;
      end else begin : g_free
        always_comb bit_en[g] = wr_en;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_r <= 1'b0;
        end else if (bit_en[g]) begin
          bit_r <= wdata[g];
        end
      end

      assign ctrl_q[g] = bit_r;
    end
  endgenerate

  // a new stop request is one that turns the stop bit on
  always_comb arm_set = wr_en && wdata[CTL_GTS] && !ctrl_q[CTL_GTS];

endmodule

// File: rtl/txseq_hb_timer.sv
module txseq_hb_timer #(
  parameter int HB_WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic col,
  output logic heard,
  output logic expire
);

  localparam int CNT_W = (HB_WIN > 1) ? $clog2(HB_WIN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_WIN - 1);

  logic [CNT_W-1:0] cnt_r, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = active || (cnt_r != '0);
    cnt_d  = active ? (cnt_r + CNT_W'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (cnt_en) begin
      cnt_r <= cnt_d;
    end
  end

  always_comb begin
    heard  = active && col;
    expire = active && !col && (cnt_r == LAST);
  end

endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
  import eth_txseq_pkg::*;
#(
  parameter int EARLY_BYTES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mac_en,
  input  logic         fdx,
  input  logic         hbc,
  input  logic         gts,
  input  logic         crs,
  input  logic         col,
  input  logic         q_avail,
  input  logic         q_eof,
  input  logic         hb_heard,
  input  logic         hb_expire,
  output txseq_state_e state,
  output logic         tx_en,
  output logic         q_rd,
  output logic         q_rewind,
  output logic         q_drop,
  output logic         hb_fail
);

  localparam int BC_W = $clog2(EARLY_BYTES + 1);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(EARLY_BYTES);

  txseq_state_e st_r, st_d;
  logic [BC_W-1:0] bc_r, bc_d;
  logic            bc_en;
  logic            line_free;
  logic            early_hit;

  always_comb begin
    line_free = fdx || !crs;
    early_hit = !fdx && col && gts && (bc_r < BC_MAX);
  end

  always_comb begin
    st_d     = st_r;
    bc_d     = bc_r;
    bc_en    = 1'b0;
    tx_en    = 1'b0;
    q_rd     = 1'b0;
    q_rewind = 1'b0;
    q_drop   = 1'b0;
    hb_fail  = 1'b0;
    unique case (st_r)
      ST_IDLE: begin
        if (mac_en && q_avail && !gts && line_free) begin
          st_d  = ST_SEND;
          bc_d  = '0;
          bc_en = 1'b1;
        end
      end
      ST_SEND: begin
        if (!mac_en) begin
          q_drop = 1'b1;
          st_d   = ST_IDLE;
        end else if (early_hit) begin
          q_rewind = 1'b1;
          st_d     = ST_HELD;
        end else begin
          tx_en = 1'b1;
          q_rd  = 1'b1;
          if (bc_r < BC_MAX) begin
            bc_d  = bc_r + BC_W'(1);
            bc_en = 1'b1;
          end
          if (q_eof) begin
            st_d = (hbc && !fdx) ? ST_HBCHK : ST_IDLE;
          end
        end
      end
      ST_HELD: begin
        if (!mac_en) begin
          q_drop = 1'b1;
          st_d   = ST_IDLE;
        end else if (!gts && line_free) begin
          st_d  = ST_SEND;
          bc_d  = '0;
          bc_en = 1'b1;
        end
      end
      ST_HBCHK: begin
        if (!mac_en || hb_heard) begin
          st_d = ST_IDLE;
        end else if (hb_expire) begin
          hb_fail = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= ST_IDLE;
    end else begin
      st_r <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_r <= '0;
    end else if (bc_en) begin
      bc_r <= bc_d;
    end
  end

  assign state = st_r;

endmodule

// File: rtl/txseq_events.sv
module txseq_events
  import eth_txseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_set,
  input  logic             gts,
  input  logic             in_frame,
  input  logic             hb_fail,
  input  logic [CLR_W-1:0] stat_clr,
  input  logic             irq_mask,
  output logic             stop_done,
  output logic             hb_err,
  output logic             irq
);

  logic armed_r, armed_d;
  logic done_r, done_d;
  logic hb_r, hb_d;
  logic fire;

  always_comb begin
    fire    = armed_r && gts && !in_frame;
    armed_d = arm_set || (armed_r && !fire);
    done_d  = fire || (done_r && !stat_clr[CLR_STOP]);
    hb_d    = hb_fail || (hb_r && !stat_clr[CLR_HB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_r <= 1'b0;
      done_r  <= 1'b0;
      hb_r    <= 1'b0;
    end else begin
      armed_r <= armed_d;
      done_r  <= done_d;
      hb_r    <= hb_d;
    end
  end

  always_comb begin
    stop_done = done_r;
    hb_err    = hb_r;
    irq       = done_r && irq_mask;
  end

endmodule

// File: rtl/eth_tx_sequencer.sv
module eth_tx_sequencer
  import eth_txseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HB_WIN      = 64,
  parameter int EARLY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_en,
  input  logic              reg_wr,
  input  logic [2:0]        reg_wdata,
  output logic [2:0]        ctrl_q,
  input  logic [1:0]        stat_clr,
  input  logic              irq_mask,
  output logic              stop_done,
  output logic              hb_err,
  output logic              irq,
  input  logic              q_avail,
  input  logic [DATA_W-1:0] q_byte,
  input  logic              q_eof,
  output logic              q_rd,
  output logic              q_rewind,
  output logic              q_drop,
  input  logic              crs,
  input  logic              col,
  output logic              tx_en,
  output logic [DATA_W-1:0] tx_data
);

  logic [1:0]   rst_pipe;
  logic         rst_sn;
  logic         arm_set;
  logic         hb_heard;
  logic         hb_expire;
  logic         hb_fail;
  txseq_state_e state;
  logic         in_hbchk;
  logic         in_frame;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  txseq_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .mac_en  (mac_en),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .arm_set (arm_set)
  );

  always_comb begin
    in_hbchk = (state == ST_HBCHK);
    in_frame = (state == ST_SEND);
  end

  txseq_hb_timer #(.HB_WIN(HB_WIN)) u_hb (
    .clk    (clk),
    .rst_n  (rst_sn),
    .active (in_hbchk),
    .col    (col),
    .heard  (hb_heard),
    .expire (hb_expire)
  );

  txseq_fsm #(.EARLY_BYTES(EARLY_BYTES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .mac_en    (mac_en),
    .fdx       (ctrl_q[CTL_FDX]),
    .hbc       (ctrl_q[CTL_HBC]),
    .gts       (ctrl_q[CTL_GTS]),
    .crs       (crs),
    .col       (col),
    .q_avail   (q_avail),
    .q_eof     (q_eof),
    .hb_heard  (hb_heard),
    .hb_expire (hb_expire),
    .state     (state),
    .tx_en     (tx_en),
    .q_rd      (q_rd),
    .q_rewind  (q_rewind),
    .q_drop    (q_drop),
    .hb_fail   (hb_fail)
  );

  txseq_events u_evt (
    .clk       (clk),
    .rst_n     (rst_sn),
    .arm_set   (arm_set),
    .gts       (ctrl_q[CTL_GTS]),
    .in_frame  (in_frame),
    .hb_fail   (hb_fail),
    .stat_clr  (stat_clr),
    .irq_mask  (irq_mask),
    .stop_done (stop_done),
    .hb_err    (hb_err),
    .irq       (irq)
  );

  assign tx_data = tx_en ? q_byte : '0;

endmodule

// File: rtl/eth_txseq_chk.sv
module eth_txseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mac_en,
  input logic [1:0] stat_clr,
  input logic [2:0] ctrl_q,
  input logic       stop_done,
  input logic       hb_err,
  input logic       tx_en,
  input logic       q_rd,
  input logic       q_rewind,
  input logic       q_drop
);

  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |=> $stable(ctrl_q[2:1]));

  // R5
  stop_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && ctrl_q[0]) |=> !tx_en);

  // R6
  stop_event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_done) |-> $past(ctrl_q[0]));

  // R8
  rewind_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_rewind |-> (!q_rd && !q_drop) ##1 !tx_en);

  // R11
  drop_needs_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_drop |-> (!mac_en && !tx_en));

  // R7
  hb_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_err) |-> $past(stat_clr[1]));

endmodule

bind eth_tx_sequencer eth_txseq_chk u_txseq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mac_en    (mac_en),
  .stat_clr  (stat_clr),
  .ctrl_q    (ctrl_q),
  .stop_done (stop_done),
  .hb_err    (hb_err),
  .tx_en     (tx_en),
  .q_rd      (q_rd),
  .q_rewind  (q_rewind),
  .q_drop    (q_drop)
);

// File: tb/test_eth_tx_sequencer.sv
module test_eth_tx_sequencer;

  localparam int DW  = 8;
  localparam int HBW = 6;
  localparam int EB  = 4;

  logic          clk;
  logic          rst_n;
  logic          mac_en;
  logic          reg_wr;
  logic [2:0]    reg_wdata;
  logic [2:0]    ctrl_q;
  logic [1:0]    stat_clr;
  logic          irq_mask;
  logic          stop_done;
  logic          hb_err;
  logic          irq;
  logic          q_avail;
  logic [DW-1:0] q_byte;
  logic          q_eof;
  logic          q_rd;
  logic          q_rewind;
  logic          q_drop;
  logic          crs;
  logic          col;
  logic          tx_en;
  logic [DW-1:0] tx_data;

  eth_tx_sequencer #(.DATA_W(DW), .HB_WIN(HBW), .EARLY_BYTES(EB)) i_eth_tx_sequencer (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .stat_clr(stat_clr), .irq_mask(irq_mask), .stop_done(stop_done),
    .hb_err(hb_err), .irq(irq), .q_avail(q_avail), .q_byte(q_byte), .q_eof(q_eof),
    .q_rd(q_rd), .q_rewind(q_rewind), .q_drop(q_drop), .crs(crs), .col(col),
    .tx_en(tx_en), .tx_data(tx_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // frame queue held by the bench
  int flen[$];
  int fids[$];
  int pos = 0;
  int next_fid = 1;

  // reference model state
  int       m_st = 0;
  int       m_bc = 0;
  int       m_hb = 0;
  bit [2:0] m_ctrl = 3'b000;
  bit       m_arm = 1'b0;
  bit       m_done = 1'b0;
  bit       m_hberr = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_q();
    q_avail = (flen.size() > 0);
    if (flen.size() > 0) begin
      q_byte = DW'((fids[0] * 16 + pos + 1) % 256);
      q_eof  = (pos == flen[0] - 1);
    end else begin
      q_byte = '0;
      q_eof  = 1'b0;
    end
  endtask

  task automatic push(input int len);
    flen.push_back(len);
    fids.push_back(next_fid);
    next_fid++;
    drive_q();
  endtask

  task automatic tick();
    bit fdx, hbc, gts, free, e_txen, e_rd, e_rew, e_drop, fail, fire, arm_set;
    bit e_irq, narm, ndone, nhberr;
    int ns, nbc, nhb;
    bit [2:0] nctrl;
    bit [DW-1:0] e_data;
    @(negedge clk);
    fdx = m_ctrl[2]; hbc = m_ctrl[1]; gts = m_ctrl[0];
    free = fdx || !crs;
    e_txen = 0; e_rd = 0; e_rew = 0; e_drop = 0; fail = 0;
    ns = m_st; nbc = m_bc;
    case (m_st)
      0: if (mac_en && q_avail && !gts && free) begin ns = 1; nbc = 0; end
      1: begin
        if (!mac_en) begin e_drop = 1; ns = 0; end
        else if (!fdx && col && gts && m_bc < EB) begin e_rew = 1; ns = 2; end
        else begin
          e_txen = 1; e_rd = 1;
          nbc = (m_bc < EB) ? m_bc + 1 : EB;
          if (q_eof) ns = (hbc && !fdx) ? 3 : 0;
        end
      end
      2: begin
        if (!mac_en) begin e_drop = 1; ns = 0; end
        else if (!gts && free) begin ns = 1; nbc = 0; end
      end
      default: begin
        if (!mac_en || col) ns = 0;
        else if (m_hb == HBW - 1) begin fail = 1; ns = 0; end
      end
    endcase
    nhb     = (m_st == 3) ? m_hb + 1 : 0;
    fire    = m_arm && gts && (m_st != 1);
    arm_set = reg_wr && reg_wdata[0] && !gts;
    narm    = arm_set || (m_arm && !fire);
    nctrl   = m_ctrl;
    if (reg_wr) begin
      nctrl[0] = reg_wdata[0];
      if (!mac_en) nctrl[2:1] = reg_wdata[2:1];
    end
    ndone  = fire || (m_done && !stat_clr[0]);
    nhberr = fail || (m_hberr && !stat_clr[1]);
    e_data = e_txen ? q_byte : '0;
    e_irq  = m_done && irq_mask;

    check(tx_en === e_txen, "R4", "tx_en", int'(tx_en), int'(e_txen));
    check(tx_data === e_data, "R4", "tx_data", int'(tx_data), int'(e_data));
    check(q_rd === e_rd, "R4", "q_rd", int'(q_rd), int'(e_rd));
    check(q_rewind === e_rew, "R8", "q_rewind", int'(q_rewind), int'(e_rew));
    check(q_drop === e_drop, "R11", "q_drop", int'(q_drop), int'(e_drop));
    check(ctrl_q === m_ctrl, "R2", "ctrl_q", int'(ctrl_q), int'(m_ctrl));
    check(stop_done === m_done, "R6", "stop_done", int'(stop_done), int'(m_done));
    check(hb_err === m_hberr, "R10", "hb_err", int'(hb_err), int'(m_hberr));
    check(irq === e_irq, "R7", "irq", int'(irq), int'(e_irq));

    @(posedge clk);
    #1;
    m_st = ns; m_bc = nbc; m_hb = nhb; m_ctrl = nctrl;
    m_arm = narm; m_done = ndone; m_hberr = nhberr;
    if (e_drop) begin
      void'(flen.pop_front()); void'(fids.pop_front()); pos = 0;
    end else if (e_rew) begin
      pos = 0;
    end else if (e_rd) begin
      if (pos == flen[0] - 1) begin
        void'(flen.pop_front()); void'(fids.pop_front()); pos = 0;
      end else begin
        pos++;
      end
    end
    reg_wr   = 1'b0;
    stat_clr = 2'b00;
    drive_q();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input bit [2:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    tick();
  endtask

  task automatic clr(input bit [1:0] c);
    stat_clr = c;
    tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mac_en = 1'b0; reg_wr = 1'b0; reg_wdata = 3'b000;
    stat_clr = 2'b00; irq_mask = 1'b0; crs = 1'b0; col = 1'b0;
    drive_q();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run(3);

    // R1 reset state
    check(ctrl_q == 3'b000, "R1", "ctrl_q", int'(ctrl_q), 0);
    check(!stop_done && !hb_err && !irq, "R1", "status", int'({stop_done, hb_err, irq}), 0);
    check(!tx_en && !q_rd, "R1", "tx idle", int'({tx_en, q_rd}), 0);

    // R2 mode bits locked while enabled, stop bit always writable
    wr(3'b110);
    check(ctrl_q == 3'b110, "R2", "ctrl disabled write", int'(ctrl_q), 6);
    mac_en = 1'b1;
    wr(3'b001);
    check(ctrl_q == 3'b111, "R2", "ctrl enabled write", int'(ctrl_q), 7);
    run(2);
    clr(2'b01);
    mac_en = 1'b0;
    wr(3'b000);
    check(ctrl_q == 3'b000, "R2", "ctrl cleared", int'(ctrl_q), 0);
    mac_en = 1'b1;

    // R3 half duplex waits for carrier to drop
    crs = 1'b1;
    push(3);
    run(5);
    check(flen.size() == 1 && pos == 0, "R3", "frame held by carrier", flen.size(), 1);
    crs = 1'b0;
    run(6);
    check(flen.size() == 0, "R4", "frame sent", flen.size(), 0);

    // R9 full duplex ignores carrier and collision
    mac_en = 1'b0;
    wr(3'b110);
    mac_en = 1'b1;
    crs = 1'b1; col = 1'b1;
    push(5);
    run(8);
    check(flen.size() == 0, "R9", "full duplex frame sent", flen.size(), 0);
    check(!hb_err, "R9", "no heartbeat in full duplex", int'(hb_err), 0);
    crs = 1'b0; col = 1'b0;
    mac_en = 1'b0;
    wr(3'b000);
    mac_en = 1'b1;

    // R6 stop while idle, R7 irq and clear, R5 stop blocks start
    wr(3'b001);
    check(!stop_done, "R6", "stop_done one edge after write", int'(stop_done), 0);
    tick();
    check(stop_done, "R6", "stop_done two edges after write", int'(stop_done), 1);
    irq_mask = 1'b1;
    tick();
    check(irq, "R7", "irq masked on", int'(irq), 1);
    irq_mask = 1'b0;
    tick();
    check(!irq, "R7", "irq masked off", int'(irq), 0);
    push(2);
    run(5);
    check(flen.size() == 1, "R5", "no start under stop", flen.size(), 1);
    clr(2'b01);
    check(!stop_done, "R7", "stop_done cleared", int'(stop_done), 0);
    wr(3'b000);
    run(5);
    check(flen.size() == 0, "R5", "sent after stop cleared", flen.size(), 0);

    // R6 stop during a frame
    push(6);
    run(2);
    wr(3'b001);
    run(2);
    check(!stop_done && flen.size() == 1, "R6", "frame still running", int'(stop_done), 0);
    run(6);
    check(stop_done && flen.size() == 0, "R6", "stop after frame", int'(stop_done), 1);
    clr(2'b01);
    wr(3'b000);

    // R8 early collision under stop holds and resends
    push(8);
    run(2);
    wr(3'b001);
    col = 1'b1;
    tick();
    col = 1'b0;
    check(flen.size() == 1 && pos == 0, "R8", "frame rewound", pos, 0);
    run(3);
    check(flen.size() == 1 && stop_done, "R8", "frame held, stop raised", flen.size(), 1);
    wr(3'b000);
    run(10);
    check(flen.size() == 0, "R8", "held frame resent", flen.size(), 0);
    clr(2'b01);

    // R8 collision without stop is ignored
    push(3);
    tick();
    col = 1'b1;
    run(3);
    col = 1'b0;
    run(2);
    check(flen.size() == 0, "R8", "collision without stop", flen.size(), 0);

    // R8 late collision under stop is ignored
    push(8);
    run(6);
    wr(3'b001);
    col = 1'b1;
    tick();
    col = 1'b0;
    run(3);
    check(flen.size() == 0, "R8", "late collision ignored", flen.size(), 0);
    clr(2'b01);
    wr(3'b000);

    // R10 heartbeat window without collision
    mac_en = 1'b0;
    wr(3'b010);
    mac_en = 1'b1;
    push(2);
    run(3);
    push(2);
    run(3);
    check(flen.size() == 1, "R10", "no start during window", flen.size(), 1);
    run(HBW);
    check(hb_err, "R10", "hb_err after silent window", int'(hb_err), 1);
    run(6);
    clr(2'b10);
    check(!hb_err, "R7", "hb_err cleared", int'(hb_err), 0);
    // R10 collision inside the window
    push(2);
    run(3);
    col = 1'b1;
    tick();
    col = 1'b0;
    run(HBW + 2);
    check(!hb_err, "R10", "no error with collision", int'(hb_err), 0);

    // R11 disable during a frame
    push(8);
    run(3);
    mac_en = 1'b0;
    tick();
    check(flen.size() == 0, "R11", "frame dropped", flen.size(), 0);
    mac_en = 1'b1;
    // R11 disable while a frame is held
    push(8);
    run(2);
    wr(3'b011);
    col = 1'b1;
    tick();
    col = 1'b0;
    run(2);
    mac_en = 1'b0;
    tick();
    check(flen.size() == 0, "R11", "held frame dropped", flen.size(), 0);
    wr(3'b000);
    clr(2'b01);
    run(2);

    summary();
    $finish;
  end

endmodule